// File: doc/BRIEF.md
# Power-Gated Fuse Read Sequencer

This block reads a contiguous run of bytes out of a one-time-programmable fuse macro. A single-cycle start pulse carries a start address, a byte count and a requested bank. The sequencer first makes sure the macro's bank select register holds the requested bank. It then brings the macro out of its power-gated state in a fixed order, with a timed settle wait. After that it fetches the bytes one address at a time over a request/ready handshake and streams each byte out with a valid strobe. At the end it gates the macro again in reverse order and closes the transfer with a one-cycle done or error pulse.

Each fetch holds the request and the address until the macro raises ready. Ready is sampled only on a slow poll tick. If ready has not appeared after a set number of polls, the transfer is abandoned. The macro is still powered down before the error is reported. All waits are counted in clock cycles through parameters, so a small configuration can run the same sequences in few cycles.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset, iso_o is 1 and wmask_dis_o, pwr_en1_o, pwr_en2_o, fuse_req_o, bank_we_o, busy_o, byte_valid_o, done_o and err_o are all 0.
- R2: Power-up changes the gating outputs one per cycle step, in this order: wmask_dis_o rises, then pwr_en1_o rises, then pwr_en2_o rises, then iso_o falls. No fuse request is made before iso_o has fallen.
- R3: At least DLY_CYC cycles pass between the rise of pwr_en1_o and the rise of pwr_en2_o. At least DLY_CYC cycles also pass between the fall of pwr_en2_o and the fall of pwr_en1_o.
- R4: Power-down runs in the reverse order: iso_o rises, then pwr_en2_o falls, then pwr_en1_o falls, then wmask_dis_o falls.
- R5: For each byte, fuse_req_o stays high and fuse_addr_o stays unchanged until fuse_rdy_i is seen on a poll tick, which comes every POLL_CYC cycles. byte_valid_o then pulses in the next cycle, with byte_data_o equal to fuse_data_i as sampled, and fuse_req_o drops.
- R6: An accepted start with count N > 0 yields exactly N byte_valid_o pulses, with byte_addr_o taking start, start+1, ..., start+N-1 in that order.
- R7: A start with count 0 pulses done_o in the next cycle. It raises no fuse request, no bank write and no gating change, and busy_o stays 0.
- R8: If ready is not seen within TMO_POLLS polls, no further address is requested. The macro is powered down and err_o pulses instead of done_o.
- R9: When bank_q_i already equals the requested bank, bank_we_o stays 0. Otherwise bank_we_o pulses once with bank_d_o equal to the request, and bank_q_i is compared again. If it still differs, err_o pulses and no power-up or fuse request takes place.
- R10: done_o and err_o are single-cycle pulses, never high together, and exactly one of them follows each accepted start.
- R11: A start pulse that arrives while busy_o is 1 has no effect on the running transfer.
- R12: done_o of a successful transfer comes only after wmask_dis_o has fallen, so that the macro is fully gated when the transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| start_addr_i | input | AW | First fuse address |
| count_i | input | CW | Number of bytes to read |
| bank_i | input | BW | Requested bank |
| bank_q_i | input | BW | Readback of the macro's bank select register |
| bank_we_o | output | 1 | Bank select write strobe |
| bank_d_o | output | BW | Bank select write value |
| wmask_dis_o | output | 1 | Write-mask disable control |
| pwr_en1_o | output | 1 | First fuse power enable |
| pwr_en2_o | output | 1 | Second fuse power enable |
| iso_o | output | 1 | Fuse-to-core isolation (1 = isolated) |
| fuse_req_o | output | 1 | Read request, held until ready |
| fuse_addr_o | output | AW | Read address |
| fuse_rdy_i | input | 1 | Macro ready flag |
| fuse_data_i | input | 8 | Macro read byte |
| byte_valid_o | output | 1 | Output byte strobe |
| byte_addr_o | output | AW | Address of the output byte |
| byte_data_o | output | 8 | Output byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Successful completion pulse |
| err_o | output | 1 | Busy-error completion pulse |

## Verification
The assertions assume that the macro raises fuse_rdy_i only while a request is pending. They also assume that bank_q_i changes only in the cycle after a bank_we_o strobe. The bench model meets both. Its ready flag is a registered function of fuse_req_o with a programmable latency, and it has a "dead" switch that never answers. Its bank register loads only on the write strobe, and a "stuck" switch can block that load. Start pulses are driven only when the bench knows whether the block is idle, with the one deliberate exception of the busy-time start test.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    T_IDLE, T_BANK_CMP, T_BANK_WR, T_BANK_CHK,
    T_PWR_UP, T_ISSUE, T_WAIT_RD, T_PWR_DN
  } top_st_t;

  typedef enum logic [3:0] {
    P_OFF, P_U_WM, P_U_E1, P_U_WT, P_U_E2, P_U_ISO,
    P_ON, P_D_ISO, P_D_E2, P_D_WT, P_D_E1, P_D_WM
  } pwr_st_t;

  typedef enum logic {B_IDLE, B_WAIT} rd_st_t;

  // Width that can hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fuse_pwr_seq.sv
module fuse_pwr_seq
  import fuse_seq_pkg::*;
#(
  parameter int unsigned DLY_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  output logic wmask_o,
  output logic en1_o,
  output logic en2_o,
  output logic iso_o,
  output logic done_o
);
  localparam int unsigned DW = cnt_width(DLY_CYC);
  localparam logic [DW-1:0] DLAST = DW'(DLY_CYC - 1);

  pwr_st_t        st;
  logic [DW-1:0]  dcnt;
  logic           wait_end;

  assign wait_end = (dcnt == DLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= P_OFF; dcnt <= '0; done_o <= 1'b0;
      wmask_o <= 1'b0; en1_o <= 1'b0; en2_o <= 1'b0; iso_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
      case (st)
        P_OFF:   if (up_i) st <= P_U_WM;
        P_U_WM:  begin wmask_o <= 1'b1; st <= P_U_E1; end
        P_U_E1:  begin en1_o <= 1'b1; dcnt <= '0; st <= P_U_WT; end
        P_U_WT:  if (wait_end) st <= P_U_E2; else dcnt <= dcnt + 1'b1;
        P_U_E2:  begin en2_o <= 1'b1; st <= P_U_ISO; end
        P_U_ISO: begin iso_o <= 1'b0; done_o <= 1'b1; st <= P_ON; end
        P_ON:    if (dn_i) st <= P_D_ISO;
        P_D_ISO: begin iso_o <= 1'b1; st <= P_D_E2; end
        P_D_E2:  begin en2_o <= 1'b0; dcnt <= '0; st <= P_D_WT; end
        P_D_WT:  if (wait_end) st <= P_D_E1; else dcnt <= dcnt + 1'b1;
        P_D_E1:  begin en1_o <= 1'b0; st <= P_D_WM; end
        P_D_WM:  begin wmask_o <= 1'b0; done_o <= 1'b1; st <= P_OFF; end
        default: st <= P_OFF;
      endcase
    end
  end
endmodule

// File: rtl/fuse_byte_rd.sv
module fuse_byte_rd
  import fuse_seq_pkg::*;
#(
  parameter int unsigned AW        = 11,
  parameter int unsigned POLL_CYC  = 250,
  parameter int unsigned TMO_POLLS = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rdy_i,
  input  logic [7:0]    din_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic [7:0]    data_o,
  output logic          ok_o,
  output logic          tmo_o,
  output logic          poll_tick_o
);
  localparam int unsigned PW = cnt_width(POLL_CYC);
  localparam int unsigned TW = cnt_width(TMO_POLLS);
  localparam logic [PW-1:0] PLAST = PW'(POLL_CYC - 1);
  localparam logic [TW-1:0] TLAST = TW'(TMO_POLLS - 1);

  rd_st_t         st;
  logic [PW-1:0]  pcnt;
  logic [TW-1:0]  tries;
  logic           tries_out;

  assign poll_tick_o = (st == B_WAIT) && (pcnt == PLAST);
  assign tries_out   = (tries == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= B_IDLE; pcnt <= '0; tries <= '0; req_o <= 1'b0;
      addr_o <= '0; valid_o <= 1'b0; data_o <= '0; ok_o <= 1'b0; tmo_o <= 1'b0;
    end else begin
      valid_o <= 1'b0; ok_o <= 1'b0; tmo_o <= 1'b0;
      case (st)
        B_IDLE: if (go_i) begin
          req_o <= 1'b1; addr_o <= addr_i; pcnt <= '0; tries <= '0; st <= B_WAIT;
        end
        B_WAIT: if (poll_tick_o) begin
          pcnt <= '0;
          if (rdy_i) begin
            req_o <= 1'b0; valid_o <= 1'b1; data_o <= din_i; ok_o <= 1'b1; st <= B_IDLE;
          end else if (tries_out) begin
            req_o <= 1'b0; tmo_o <= 1'b1; st <= B_IDLE;
          end else begin
            tries <= tries + 1'b1;
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_seq_pkg::*;
#(
  parameter int unsigned AW        = 11,
  parameter int unsigned CW        = 12,
  parameter int unsigned BW        = 1,
  parameter int unsigned DLY_CYC   = 250000,
  parameter int unsigned POLL_CYC  = 250,
  parameter int unsigned TMO_POLLS = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [BW-1:0] bank_i,
  input  logic [BW-1:0] bank_q_i,
  output logic          bank_we_o,
  output logic [BW-1:0] bank_d_o,
  output logic          wmask_dis_o,
  output logic          pwr_en1_o,
  output logic          pwr_en2_o,
  output logic          iso_o,
  output logic          fuse_req_o,
  output logic [AW-1:0] fuse_addr_o,
  input  logic          fuse_rdy_i,
  input  logic [7:0]    fuse_data_i,
  output logic          byte_valid_o,
  output logic [AW-1:0] byte_addr_o,
  output logic [7:0]    byte_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  top_st_t        st;
  logic [AW-1:0]  cur_addr;
  logic [CW-1:0]  remain;
  logic [BW-1:0]  bank_r;
  logic           fail_r;

  // Named internal events
  logic up_req, dn_req, pwr_done, rd_go, rd_ok, rd_tmo, poll_tick, last_byte, bank_match;

  assign up_req     = (st == T_PWR_UP);
  assign dn_req     = (st == T_PWR_DN);
  assign rd_go      = (st == T_ISSUE);
  assign last_byte  = (remain == CW'(1));
  assign bank_match = (bank_q_i == bank_r);
  assign busy_o     = (st != T_IDLE);
  assign bank_d_o   = bank_r;
  assign byte_addr_o = fuse_addr_o;

  fuse_pwr_seq #(.DLY_CYC(DLY_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .up_i(up_req), .dn_i(dn_req),
    .wmask_o(wmask_dis_o), .en1_o(pwr_en1_o), .en2_o(pwr_en2_o),
    .iso_o(iso_o), .done_o(pwr_done)
  );

  fuse_byte_rd #(.AW(AW), .POLL_CYC(POLL_CYC), .TMO_POLLS(TMO_POLLS)) u_rd (
    .clk(clk), .rst_n(rst_n), .go_i(rd_go), .addr_i(cur_addr),
    .rdy_i(fuse_rdy_i), .din_i(fuse_data_i), .req_o(fuse_req_o),
    .addr_o(fuse_addr_o), .valid_o(byte_valid_o), .data_o(byte_data_o),
    .ok_o(rd_ok), .tmo_o(rd_tmo), .poll_tick_o(poll_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; cur_addr <= '0; remain <= '0; bank_r <= '0;
      fail_r <= 1'b0; bank_we_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      bank_we_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
      case (st)
        T_IDLE: if (start_i) begin
          if (count_i == '0) begin
            done_o <= 1'b1;
          end else begin
            cur_addr <= start_addr_i; remain <= count_i; bank_r <= bank_i;
            fail_r <= 1'b0; st <= T_BANK_CMP;
          end
        end
        T_BANK_CMP: if (bank_match) st <= T_PWR_UP;
                    else begin bank_we_o <= 1'b1; st <= T_BANK_WR; end
        T_BANK_WR:  st <= T_BANK_CHK;
        T_BANK_CHK: if (bank_match) st <= T_PWR_UP;
                    else begin err_o <= 1'b1; st <= T_IDLE; end
        T_PWR_UP:   if (pwr_done) st <= T_ISSUE;
        T_ISSUE:    st <= T_WAIT_RD;
        T_WAIT_RD: begin
          if (rd_tmo) begin
            fail_r <= 1'b1; st <= T_PWR_DN;
          end else if (rd_ok) begin
            if (last_byte) st <= T_PWR_DN;
            else begin
              cur_addr <= cur_addr + 1'b1; remain <= remain - 1'b1; st <= T_ISSUE;
            end
          end
        end
        T_PWR_DN: if (pwr_done) begin
          done_o <= !fail_r; err_o <= fail_r; st <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_read_seq_chk.sv
module fuse_read_seq_chk
  import fuse_seq_pkg::*;
#(
  parameter int unsigned AW      = 11,
  parameter int unsigned DLY_CYC = 250000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wmask_dis_o,
  input logic          pwr_en1_o,
  input logic          pwr_en2_o,
  input logic          iso_o,
  input logic          fuse_req_o,
  input logic [AW-1:0] fuse_addr_o,
  input logic          fuse_rdy_i,
  input logic          byte_valid_o,
  input logic          bank_we_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          poll_tick,
  input logic          rd_ok
);
  localparam int unsigned GW = cnt_width(DLY_CYC + 2);
  localparam logic [GW-1:0] GMAX = '1;
  logic [GW-1:0] gap;

  // Cycles spent with only the first enable on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (!pwr_en1_o || pwr_en2_o) gap <= '0;
    else if (gap != GMAX) gap <= gap + 1'b1;
  end

  AST_EN1_NEEDS_WMASK:  assert property (@(posedge clk) disable iff (!rst_n) pwr_en1_o |-> wmask_dis_o);      // R2
  AST_EN2_NEEDS_EN1:    assert property (@(posedge clk) disable iff (!rst_n) pwr_en2_o |-> pwr_en1_o);        // R2
  AST_OPEN_NEEDS_EN2:   assert property (@(posedge clk) disable iff (!rst_n) !iso_o |-> pwr_en2_o);           // R4
  AST_REQ_NEEDS_OPEN:   assert property (@(posedge clk) disable iff (!rst_n) fuse_req_o |-> !iso_o);          // R2
  AST_UP_SETTLE:        assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_en2_o) |-> gap >= GW'(DLY_CYC)); // R3
  AST_DOWN_SETTLE:      assert property (@(posedge clk) disable iff (!rst_n) $fell(pwr_en1_o) |-> gap >= GW'(DLY_CYC)); // R3
  AST_ADDR_HELD:        assert property (@(posedge clk) disable iff (!rst_n) fuse_req_o && $past(fuse_req_o) |-> $stable(fuse_addr_o)); // R5
  AST_VALID_AFTER_RDY:  assert property (@(posedge clk) disable iff (!rst_n) byte_valid_o |-> $past(fuse_rdy_i && poll_tick)); // R5
  AST_VALID_WITH_OK:    assert property (@(posedge clk) disable iff (!rst_n) byte_valid_o |-> rd_ok);         // R5
  AST_DONE_PULSE:       assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);             // R10
  AST_ERR_PULSE:        assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !err_o);               // R10
  AST_DONE_ERR_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o));             // R10
  AST_BANK_WE_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) bank_we_o |-> busy_o);           // R9
  AST_DONE_GATED:       assert property (@(posedge clk) disable iff (!rst_n) done_o |-> iso_o && !wmask_dis_o); // R12
endmodule

bind fuse_read_seq fuse_read_seq_chk #(.AW(AW), .DLY_CYC(DLY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wmask_dis_o(wmask_dis_o), .pwr_en1_o(pwr_en1_o),
  .pwr_en2_o(pwr_en2_o), .iso_o(iso_o), .fuse_req_o(fuse_req_o),
  .fuse_addr_o(fuse_addr_o), .fuse_rdy_i(fuse_rdy_i), .byte_valid_o(byte_valid_o),
  .bank_we_o(bank_we_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .poll_tick(poll_tick), .rd_ok(rd_ok)
);

// File: tb/test_fuse_read_seq.sv
module test_fuse_read_seq;
  localparam int AW = 6, CW = 4, BW = 2;
  localparam int DLY = 6, POLL = 3, TMO = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [BW-1:0] bank_i = '0, bank_q_i, bank_d_o;
  logic bank_we_o, wmask_dis_o, pwr_en1_o, pwr_en2_o, iso_o, fuse_req_o;
  logic [AW-1:0] fuse_addr_o, byte_addr_o;
  logic fuse_rdy_i;
  logic [7:0] fuse_data_i, byte_data_o;
  logic byte_valid_o, busy_o, done_o, err_o;

  always #2 clk = ~clk;  // 250 MHz

  fuse_read_seq #(.AW(AW), .CW(CW), .BW(BW), .DLY_CYC(DLY), .POLL_CYC(POLL), .TMO_POLLS(TMO))
  i_fuse_read_seq (.*);

  // ---------------- macro model ----------------
  int lat = 1;
  bit dead = 0, stuck = 0, bank_load = 0;
  logic [BW-1:0] bank_init = '0, bank_reg;
  int mcnt;
  logic rdy_r;

  function automatic logic [7:0] fval(input int a);
    return 8'(((a * 29) + 7) ^ 8'h5C);
  endfunction

  always @(posedge clk) begin
    if (!fuse_req_o) begin mcnt <= 0; rdy_r <= 1'b0; end
    else if (!dead) begin mcnt <= mcnt + 1; if (mcnt >= lat) rdy_r <= 1'b1; end
    if (bank_load) bank_reg <= bank_init;
    else if (bank_we_o && !stuck) bank_reg <= bank_d_o;
  end
  assign fuse_rdy_i  = rdy_r === 1'b1;
  assign fuse_data_i = fval(int'(fuse_addr_o));
  assign bank_q_i    = bank_reg;

  // ---------------- monitor ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ev[16]; int n_ev;
  int v_addr[16]; int v_data[16]; int n_val;
  int n_done, n_err, n_req, n_bwe, t_done, t_err, t_req;
  int t_e1r, t_e2r, t_e2f, t_e1f, t_wmf;
  bit busy_seen;
  logic p_wm = 0, p_e1 = 0, p_e2 = 0, p_iso = 1, p_req = 0;

  task automatic log_ev(input int c);
    if (n_ev < 16) ev[n_ev] = c;
    n_ev++;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wmask_dis_o && !p_wm) log_ev(1);
    if (pwr_en1_o && !p_e1) begin log_ev(2); t_e1r = cyc; end
    if (pwr_en2_o && !p_e2) begin log_ev(3); t_e2r = cyc; end
    if (!iso_o && p_iso) log_ev(4);
    if (iso_o && !p_iso) log_ev(5);
    if (!pwr_en2_o && p_e2) begin log_ev(6); t_e2f = cyc; end
    if (!pwr_en1_o && p_e1) begin log_ev(7); t_e1f = cyc; end
    if (!wmask_dis_o && p_wm) begin log_ev(8); t_wmf = cyc; end
    if (fuse_req_o && !p_req) begin if (n_req == 0) t_req = cyc; n_req++; end
    if (byte_valid_o) begin
      if (n_val < 16) begin v_addr[n_val] = int'(byte_addr_o); v_data[n_val] = int'(byte_data_o); end
      n_val++;
    end
    if (done_o) begin n_done++; t_done = cyc; end
    if (err_o) begin n_err++; t_err = cyc; end
    if (bank_we_o) n_bwe++;
    if (busy_o) busy_seen = 1;
    p_wm = wmask_dis_o; p_e1 = pwr_en1_o; p_e2 = pwr_en2_o; p_iso = iso_o; p_req = fuse_req_o;
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  int t_start;
  task automatic set_bank(input int b);
    @(negedge clk); bank_init = BW'(b); bank_load = 1;
    @(negedge clk); bank_load = 0;
  endtask

  task automatic run(input int sa, input int cnt, input int bk, input bit inject);
    n_ev = 0; n_val = 0; n_done = 0; n_err = 0; n_req = 0; n_bwe = 0; busy_seen = 0;
    t_e1r = 0; t_e2r = 0; t_e2f = 0; t_e1f = 0; t_wmf = 0; t_done = 0; t_err = 0;
    @(negedge clk);
    start_addr_i = AW'(sa); count_i = CW'(cnt); bank_i = BW'(bk); start_i = 1; t_start = cyc;
    @(negedge clk); start_i = 0;
    if (inject) begin
      repeat (5) @(negedge clk);
      start_addr_i = AW'(30); count_i = CW'(7); start_i = 1;
      @(negedge clk); start_i = 0;
    end
    for (int w = 0; w < 600 && (n_done + n_err) == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_power(input string tg);
    int up_seq[4] = '{1, 2, 3, 4};
    int dn_seq[4] = '{5, 6, 7, 8};
    chk(n_ev == 8, {tg, " R2 R4 event count"}, n_ev, 8);
    for (int i = 0; i < 4; i++) begin
      chk(ev[i] == up_seq[i], {tg, " R2 up order"}, ev[i], up_seq[i]);
      chk(ev[i+4] == dn_seq[i], {tg, " R4 down order"}, ev[i+4], dn_seq[i]);
    end
    chk(t_e2r - t_e1r >= DLY, {tg, " R3 up settle"}, t_e2r - t_e1r, DLY);
    chk(t_e1f - t_e2f >= DLY, {tg, " R3 down settle"}, t_e1f - t_e2f, DLY);
  endtask

  task automatic check_good(input int sa, input int cnt);
    chk(n_done == 1, "R10 one done", n_done, 1);
    chk(n_err == 0, "R10 no err", n_err, 0);
    chk(n_val == cnt, "R6 byte count", n_val, cnt);
    chk(n_req == cnt, "R5 one request per byte", n_req, cnt);
    for (int i = 0; i < cnt && i < 16; i++) begin
      chk(v_addr[i] == sa + i, "R6 ascending address", v_addr[i], sa + i);
      chk(v_data[i] == int'(fval(sa + i)), "R5 byte data", v_data[i], int'(fval(sa + i)));
    end
    check_power("good");
    chk(t_done > t_wmf, "R12 done after gating", t_done, t_wmf + 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(iso_o == 1'b1, "R1 iso", int'(iso_o), 1);
    chk({wmask_dis_o, pwr_en1_o, pwr_en2_o} == 3'b000, "R1 gating low",
        int'({wmask_dis_o, pwr_en1_o, pwr_en2_o}), 0);
    chk({fuse_req_o, bank_we_o, busy_o, byte_valid_o, done_o, err_o} == 6'b0, "R1 strobes low",
        int'({fuse_req_o, bank_we_o, busy_o, byte_valid_o, done_o, err_o}), 0);

    set_bank(1);
    // R5 R6 sweep over latency, start, count; bank already matches (R9)
    foreach (lat_set[li]) ;
    for (int li = 0; li < 3; li++) begin
      lat = (li == 0) ? 1 : (li == 1) ? 4 : 9;
      for (int si = 0; si < 4; si++) begin
        int sa = (si == 0) ? 0 : (si == 1) ? 5 : (si == 2) ? 40 : 58;
        for (int c = 1; c <= 5; c++) begin
          run(sa, c, 1, 0);
          check_good(sa, c);
          chk(n_bwe == 0, "R9 no write when bank matches", n_bwe, 0);
        end
      end
    end

    // R7 zero count
    lat = 1;
    run(12, 0, 1, 0);
    chk(n_done == 1 && n_err == 0, "R7 zero count done", n_done, 1);
    chk(t_done - t_start <= 2, "R7 done at once", t_done - t_start, 1);
    chk(n_ev == 0 && n_req == 0 && n_bwe == 0, "R7 macro untouched", n_ev + n_req + n_bwe, 0);
    chk(!busy_seen, "R7 busy stays low", int'(busy_seen), 0);

    // R9 bank mismatch fixed by one write
    set_bank(0);
    run(20, 2, 2, 0);
    chk(n_bwe == 1, "R9 single bank write", n_bwe, 1);
    chk(bank_reg == 2'd2, "R9 bank written", int'(bank_reg), 2);
    check_good(20, 2);

    // R9 bank write does not stick
    stuck = 1; set_bank(0);
    run(20, 2, 3, 0);
    chk(n_err == 1 && n_done == 0, "R9 stuck bank error", n_err, 1);
    chk(n_ev == 0 && n_req == 0, "R9 no power up on bank error", n_ev + n_req, 0);
    chk(n_bwe == 1, "R9 one write attempt", n_bwe, 1);
    stuck = 0; set_bank(1);

    // R8 timeout
    dead = 1;
    run(10, 4, 1, 0);
    chk(n_err == 1 && n_done == 0, "R8 busy error", n_err, 1);
    chk(n_val == 0, "R8 no byte", n_val, 0);
    chk(n_req == 1, "R8 no further address", n_req, 1);
    check_power("tmo");
    chk(t_err - t_req >= POLL * TMO, "R8 full timeout window", t_err - t_req, POLL * TMO);
    dead = 0;

    // R11 start while busy ignored
    lat = 2;
    run(2, 3, 1, 1);
    check_good(2, 3);
    chk(n_val == 3, "R11 extra start ignored", n_val, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
  int lat_set[1];
endmodule